// File: doc/BRIEF.md
# Byte/Word CPU Register Bank with Flag Nibble

An 8-bit processor register bank holding eight byte registers and two 16-bit pointers. The byte registers are the accumulator A, the flag register F, and the general registers B, C, D, E, H and L. The pointers are the stack pointer and the program counter. The same byte storage can be reached one byte at a time through a byte port. It can also be reached two bytes at a time, as the pairs AF, BC, DE and HL, through a word port. The word port is the only path to the two pointers.

Only the upper four bits of F exist in hardware. Its low nibble reads as zero whatever is written and on whichever path. Four single-bit helpers set, clear or read one flag of that upper nibble. The reset contents depend on a model code. For two of the models they also depend on whether the inserted cartridge targets colour mode. Both inputs are sampled on the reset clock edge.

Reads are combinational. Writes take effect on the next rising clock edge. The block contains no decode, arithmetic or memory access logic; it only holds and presents register state.

Top module: `cpu_regbank`

## Requirements
- R1: Byte port selects A=0, F=1, B=2, C=3, D=4, E=5, H=6, L=7. A byte write with `b_we` high stores all 8 bits of A, B, C, D, E, H or L at the next rising edge. `b_rdata` combinationally shows the selected register.
- R2: F keeps only bits 7..4 on the byte path, the word path (AF) and at reset, and its bits 3..0 always read as zero. For example, byte 0x66 reads back as 0x60 and AF=0x1234 reads back as 0x1230.
- R3: Word selects AF=0, BC=1, DE=2, HL=3. In each pair the first-named register is the high byte: BC=0x9775 gives B=0x97 and C=0x75. A byte write is visible through the pair view from the next cycle: A=0x15 followed by F=0x12 reads as AF=0x1510.
- R4: Word select 4 is SP and word select 5 is PC. Both are full 16-bit registers with no masking, so a written value reads back unchanged. The byte port never changes them.
- R5: When both ports write in the same cycle and the word write covers the byte register the byte port names, the word data wins. When the two writes do not overlap, both take effect.
- R6: `flag_idx` 0, 1, 2 and 3 select F bits 7 (Z), 6 (N), 5 (H) and 4 (C). `flag_set` sets the selected bit and `flag_clr` clears it. Set wins when both are high. A byte or word write of F in the same cycle overrides the flag operation. `flag_rd` combinationally shows the selected bit.
- R7: Reset loads the pairs for `model_sel`. Code 0 loads AF=0x01B0, BC=0x0013, DE=0x00D8, HL=0x014D. Code 1 loads AF=0x0100, BC=0x0014, DE=0x0000, HL=0xC060. Code 2 loads AF=0x1180 and BC=0x0000. Code 3 loads AF=0x1100 and BC=0x0100. For codes 2 and 3, DE=0xFF56 and HL=0x000D when `colour_tgt` is 1, and DE=0x0008 and HL=0x007C otherwise.
- R8: Reset loads PC with 0x0100 and SP with 0xFFFE.
- R9: Word selects 6 and 7 read as 0x0000, and writes to them change no register.
- R10: Reset is synchronous and active high. `model_sel` and `colour_tgt` act only on a clock edge that has `rst` high; changing them at any other time leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| model_sel | input | 2 | Console model code for the reset contents |
| colour_tgt | input | 1 | Cartridge targets colour mode (reset contents) |
| b_sel | input | 3 | Byte register select |
| b_we | input | 1 | Byte write enable |
| b_wdata | input | 8 | Byte write data |
| b_rdata | output | 8 | Selected byte register |
| w_sel | input | 3 | Word register select |
| w_we | input | 1 | Word write enable |
| w_wdata | input | 16 | Word write data |
| w_rdata | output | 16 | Selected pair or pointer |
| flag_idx | input | 2 | Flag bit select |
| flag_set | input | 1 | Set the selected flag |
| flag_clr | input | 1 | Clear the selected flag |
| flag_rd | output | 1 | Value of the selected flag |

## Verification
Every stored bit reaches `b_rdata` or `w_rdata` through a purely combinational path. A wrong write, a lost write or a wrong reset value therefore shows at the ports in the cycle that follows the faulty clock edge, as soon as the affected register is selected. Writing to the wrong byte lane shows as a mismatch in the byte that should have stayed unchanged, so the bench compares the whole register set after each mixed-port and flag operation. Sweeps over every byte value expose a lost or extra bit of the F mask. Sweeps over all model and target combinations expose a wrong entry in the reset decode.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   // Byte register codes; pair p occupies codes 2p (high) and 2p+1 (low).
   typedef enum logic [2:0] {
      BR_A = 3'd0, BR_F = 3'd1, BR_B = 3'd2, BR_C = 3'd3,
      BR_D = 3'd4, BR_E = 3'd5, BR_H = 3'd6, BR_L = 3'd7
   } byte_reg_e;

   typedef enum logic [2:0] {
      WP_AF = 3'd0, WP_BC = 3'd1, WP_DE = 3'd2, WP_HL = 3'd3,
      WP_SP = 3'd4, WP_PC = 3'd5, WP_NUL6 = 3'd6, WP_NUL7 = 3'd7
   } word_reg_e;

   typedef enum logic [1:0] {
      MD_MONO = 2'd0, MD_SUPER = 2'd1, MD_COLOUR = 2'd2, MD_ADVANCE = 2'd3
   } model_e;

   typedef struct packed {
      logic [15:0] af;
      logic [15:0] bc;
      logic [15:0] de;
      logic [15:0] hl;
   } pair_set_t;

endpackage

// File: rtl/regbank_reset_rom.sv
module regbank_reset_rom
   import regbank_pkg::*;
(
   input  logic [1:0] model,
   input  logic       colour_tgt,
   output pair_set_t  vals
);

   logic [15:0] de_colour;
   logic [15:0] hl_colour;

   assign de_colour = colour_tgt ? 16'hFF56 : 16'h0008;
   assign hl_colour = colour_tgt ? 16'h000D : 16'h007C;

   always_comb begin
      vals = '0;
      case (model_e'(model))
         MD_MONO: begin
            vals.af = 16'h01B0;
            vals.bc = 16'h0013;
            vals.de = 16'h00D8;
            vals.hl = 16'h014D;
         end
         MD_SUPER: begin
            vals.af = 16'h0100;
            vals.bc = 16'h0014;
            vals.de = 16'h0000;
            vals.hl = 16'hC060;
         end
         MD_COLOUR: begin
            vals.af = 16'h1180;
            vals.bc = 16'h0000;
            vals.de = de_colour;
            vals.hl = hl_colour;
         end
         MD_ADVANCE: begin
            vals.af = 16'h1100;
            vals.bc = 16'h0100;
            vals.de = de_colour;
            vals.hl = hl_colour;
         end
         default: vals = '0;
      endcase
   end

endmodule

// File: rtl/regbank_byte_cell.sv
module regbank_byte_cell #(
   parameter int unsigned W    = 8,
   parameter logic [W-1:0] LIVE = {W{1'b1}}
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] rst_val,
   input  logic         we,
   input  logic [W-1:0] wd,
   output logic [W-1:0] q
);

   initial begin
      if (LIVE == '0) $error("regbank_byte_cell: no live bits");
   end

   // Only live bits get a flop; dead bits are constant zero.
   for (genvar b = 0; b < W; b++) begin : g_bit
      if (LIVE[b]) begin : g_ff
         logic r;
         always_ff @(posedge clk) begin
            if (rst)     r <= rst_val[b];
            else if (we) r <= wd[b];
         end
         assign q[b] = r;
      end else begin : g_tie
         logic unused_b;
         assign unused_b = rst_val[b] ^ wd[b];
         assign q[b]     = 1'b0;
      end
   end

endmodule

// File: rtl/regbank_flag_ops.sv
module regbank_flag_ops #(
   parameter int unsigned W  = 8,
   parameter int unsigned NF = 4,
   localparam int unsigned IW = (NF > 1) ? $clog2(NF) : 1
) (
   input  logic [W-1:0]  f_cur,
   input  logic [IW-1:0] idx,
   input  logic          set_i,
   input  logic          clr_i,
   output logic [W-1:0]  f_next,
   output logic          upd,
   output logic [W-1:0]  sel_mask,
   output logic          bit_rd
);

   initial begin
      if (NF == 0 || NF > W) $error("regbank_flag_ops: bad flag count");
   end

   // Flag k sits at bit W-1-k.
   always_comb begin
      sel_mask = '0;
      for (int k = 0; k < NF; k++) begin
         if (idx == IW'(k)) sel_mask[W-1-k] = 1'b1;
      end
   end

   assign upd    = set_i | clr_i;
   assign f_next = set_i ? (f_cur | sel_mask) : (f_cur & ~sel_mask);
   assign bit_rd = |(f_cur & sel_mask);

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
   import regbank_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned NFLAGS   = 4,
   parameter logic [15:0] PC_RESET = 16'h0100,
   parameter logic [15:0] SP_RESET = 16'hFFFE
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [1:0]  model_sel,
   input  logic        colour_tgt,
   input  logic [2:0]  b_sel,
   input  logic        b_we,
   input  logic [7:0]  b_wdata,
   output logic [7:0]  b_rdata,
   input  logic [2:0]  w_sel,
   input  logic        w_we,
   input  logic [15:0] w_wdata,
   output logic [15:0] w_rdata,
   input  logic [1:0]  flag_idx,
   input  logic        flag_set,
   input  logic        flag_clr,
   output logic        flag_rd
);

   localparam int unsigned WORD_W = 2 * BYTE_W;
   localparam int unsigned NREG   = 8;
   localparam int unsigned NPAIR  = NREG / 2;
   localparam int unsigned FIDX   = int'(BR_F);
   localparam logic [BYTE_W-1:0] F_LIVE =
      {{NFLAGS{1'b1}}, {(BYTE_W-NFLAGS){1'b0}}};

   initial begin
      if (BYTE_W != 8)                   $error("cpu_regbank: reset table needs 8-bit bytes");
      if (NFLAGS < 1 || NFLAGS >= BYTE_W) $error("cpu_regbank: NFLAGS out of range");
   end

   // ---------------- reset contents ----------------
   pair_set_t         rv;
   logic [WORD_W-1:0] pair_rv [NPAIR];

   regbank_reset_rom u_rom (
      .model      (model_sel),
      .colour_tgt (colour_tgt),
      .vals       (rv)
   );

   assign pair_rv[0] = rv.af;
   assign pair_rv[1] = rv.bc;
   assign pair_rv[2] = rv.de;
   assign pair_rv[3] = rv.hl;

   // ---------------- flag helpers ----------------
   logic [BYTE_W-1:0] q [NREG];
   logic [BYTE_W-1:0] f_next;
   logic [BYTE_W-1:0] f_sel_mask;
   logic              f_upd;

   regbank_flag_ops #(.W(BYTE_W), .NF(NFLAGS)) u_flags (
      .f_cur    (q[FIDX]),
      .idx      (flag_idx),
      .set_i    (flag_set),
      .clr_i    (flag_clr),
      .f_next   (f_next),
      .upd      (f_upd),
      .sel_mask (f_sel_mask),
      .bit_rd   (flag_rd)
   );

   // ---------------- byte storage ----------------
   logic [NPAIR-1:0] pair_hit;
   for (genvar p = 0; p < NPAIR; p++) begin : g_hit
      assign pair_hit[p] = w_we && (w_sel == 3'(p));
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam int unsigned P  = i / 2;
      localparam bit          HI = (i % 2) == 0;
      localparam logic [BYTE_W-1:0] LIVE = (i == FIDX) ? F_LIVE : {BYTE_W{1'b1}};

      logic              we;
      logic [BYTE_W-1:0] wd;
      logic [BYTE_W-1:0] rst_byte;
      logic [BYTE_W-1:0] word_byte;
      logic              byte_hit;

      assign rst_byte  = HI ? pair_rv[P][WORD_W-1:BYTE_W] : pair_rv[P][BYTE_W-1:0];
      assign word_byte = HI ? w_wdata[WORD_W-1:BYTE_W]    : w_wdata[BYTE_W-1:0];
      assign byte_hit  = b_we && (b_sel == 3'(i));

      // Priority: word port, then byte port, then flag helper (F only).
      if (i == FIDX) begin : g_fsrc
         always_comb begin
            we = 1'b1;
            if (pair_hit[P])   wd = word_byte;
            else if (byte_hit) wd = b_wdata;
            else if (f_upd)    wd = f_next;
            else begin
               we = 1'b0;
               wd = q[i];
            end
         end
      end else begin : g_src
         always_comb begin
            we = pair_hit[P] | byte_hit;
            wd = pair_hit[P] ? word_byte : b_wdata;
         end
      end

      regbank_byte_cell #(.W(BYTE_W), .LIVE(LIVE)) u_cell (
         .clk     (clk),
         .rst     (rst),
         .rst_val (rst_byte),
         .we      (we),
         .wd      (wd),
         .q       (q[i])
      );
   end

   // ---------------- pointers ----------------
   logic [WORD_W-1:0] sp_q;
   logic [WORD_W-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sp_q <= SP_RESET;
         pc_q <= PC_RESET;
      end else if (w_we) begin
         if (w_sel == WP_SP) sp_q <= w_wdata;
         if (w_sel == WP_PC) pc_q <= w_wdata;
      end
   end

   // ---------------- read paths ----------------
   assign b_rdata = q[b_sel];

   always_comb begin
      case (word_reg_e'(w_sel))
         WP_AF:   w_rdata = {q[0], q[1]};
         WP_BC:   w_rdata = {q[2], q[3]};
         WP_DE:   w_rdata = {q[4], q[5]};
         WP_HL:   w_rdata = {q[6], q[7]};
         WP_SP:   w_rdata = sp_q;
         WP_PC:   w_rdata = pc_q;
         default: w_rdata = '0;
      endcase
   end

   // ---------------- assertions ----------------
   a_r2_af_low_zero: assert property (@(posedge clk) disable iff (rst)
      (w_sel == WP_AF) |-> (w_rdata[3:0] == 4'h0));

   a_r4_pc_load: assert property (@(posedge clk) disable iff (rst)
      (w_we && w_sel == WP_PC) |=> (pc_q == $past(w_wdata)));

   a_r4_sp_load: assert property (@(posedge clk) disable iff (rst)
      (w_we && w_sel == WP_SP) |=> (sp_q == $past(w_wdata)));

   a_r5_word_wins: assert property (@(posedge clk) disable iff (rst)
      (w_we && w_sel == WP_BC && b_we && b_sel == BR_C) |=> (q[3] == $past(w_wdata[7:0])));

   a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
      (flag_set && !(b_we && b_sel == BR_F) && !(w_we && w_sel == WP_AF))
      |=> ((q[FIDX] & $past(f_sel_mask)) != '0));

   a_r6_flag_clr: assert property (@(posedge clk) disable iff (rst)
      (flag_clr && !flag_set && !(b_we && b_sel == BR_F) && !(w_we && w_sel == WP_AF))
      |=> ((q[FIDX] & $past(f_sel_mask)) == '0));

   a_r8_ptr_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pc_q == PC_RESET && sp_q == SP_RESET));

   a_r9_null_read: assert property (@(posedge clk) disable iff (rst)
      (w_sel == WP_NUL6 || w_sel == WP_NUL7) |-> (w_rdata == '0));

   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      (!b_we && !w_we && !flag_set && !flag_clr) |=> ($stable(pc_q) && $stable(sp_q) && $stable(q[0])));

endmodule

// File: tb/sim_cpu_regbank.sv
`timescale 1ns/10ps
module sim_cpu_regbank;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  model_sel = 2'd0;
   logic        colour_tgt = 1'b0;
   logic [2:0]  b_sel = 3'd0;
   logic        b_we = 1'b0;
   logic [7:0]  b_wdata = 8'h00;
   logic [7:0]  b_rdata;
   logic [2:0]  w_sel = 3'd0;
   logic        w_we = 1'b0;
   logic [15:0] w_wdata = 16'h0000;
   logic [15:0] w_rdata;
   logic [1:0]  flag_idx = 2'd0;
   logic        flag_set = 1'b0;
   logic        flag_clr = 1'b0;
   logic        flag_rd;

   always #5 clk = ~clk;

   cpu_regbank u0 (
      .clk(clk), .rst(rst), .model_sel(model_sel), .colour_tgt(colour_tgt),
      .b_sel(b_sel), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata),
      .w_sel(w_sel), .w_we(w_we), .w_wdata(w_wdata), .w_rdata(w_rdata),
      .flag_idx(flag_idx), .flag_set(flag_set), .flag_clr(flag_clr), .flag_rd(flag_rd)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [7:0]  eb [8];
   logic [15:0] esp, epc;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Called at a falling edge: let one rising edge pass, then drop strobes.
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0; b_we = 1'b0; w_we = 1'b0; flag_set = 1'b0; flag_clr = 1'b0;
   endtask

   function automatic logic [15:0] exp_word(input int s);
      if (s < 4)       return {eb[2*s], eb[2*s+1]};
      else if (s == 4) return esp;
      else if (s == 5) return epc;
      else             return 16'h0000;
   endfunction

   task automatic verify_all(input string tag);
      for (int i = 0; i < 8; i++) begin
         b_sel = 3'(i); #0.1;
         chk(tag, {8'h00, b_rdata}, {8'h00, eb[i]});
      end
      for (int s = 0; s < 8; s++) begin
         w_sel = 3'(s); #0.1;
         chk(tag, w_rdata, exp_word(s));
      end
   endtask

   task automatic load_pair(input int p, input logic [15:0] v);
      eb[2*p]   = v[15:8];
      eb[2*p+1] = (p == 0) ? (v[7:0] & 8'hF0) : v[7:0];
   endtask

   task automatic do_reset(input int m, input bit t);
      logic [15:0] de_c, hl_c;
      rst = 1'b1; model_sel = 2'(m); colour_tgt = t;
      step();
      de_c = t ? 16'hFF56 : 16'h0008;
      hl_c = t ? 16'h000D : 16'h007C;
      case (m)
         0: begin load_pair(0,16'h01B0); load_pair(1,16'h0013); load_pair(2,16'h00D8); load_pair(3,16'h014D); end
         1: begin load_pair(0,16'h0100); load_pair(1,16'h0014); load_pair(2,16'h0000); load_pair(3,16'hC060); end
         2: begin load_pair(0,16'h1180); load_pair(1,16'h0000); load_pair(2,de_c);     load_pair(3,hl_c);     end
         default: begin load_pair(0,16'h1100); load_pair(1,16'h0100); load_pair(2,de_c); load_pair(3,hl_c); end
      endcase
      esp = 16'hFFFE; epc = 16'h0100;
   endtask

   task automatic wr_byte(input int i, input logic [7:0] v);
      b_sel = 3'(i); b_wdata = v; b_we = 1'b1;
      step();
      eb[i] = (i == 1) ? (v & 8'hF0) : v;
   endtask

   task automatic upd_word(input int s, input logic [15:0] v);
      if (s < 4)       load_pair(s, v);
      else if (s == 4) esp = v;
      else if (s == 5) epc = v;
   endtask

   task automatic wr_word(input int s, input logic [15:0] v);
      w_sel = 3'(s); w_wdata = v; w_we = 1'b1;
      step();
      upd_word(s, v);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired, run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);

      // R7 / R8: reset contents for every model and target
      for (int m = 0; m < 4; m++) begin
         for (int t = 0; t < 2; t++) begin
            do_reset(m, 1'(t));
            verify_all("R7");
            w_sel = 3'd4; #0.1; chk("R8", w_rdata, 16'hFFFE);
            w_sel = 3'd5; #0.1; chk("R8", w_rdata, 16'h0100);
         end
      end

      // R10: model inputs outside reset have no effect
      do_reset(2, 1'b1);
      model_sel = 2'd0; colour_tgt = 1'b0;
      step(); step();
      verify_all("R10");

      // R2 / R3: named examples
      wr_byte(0, 8'h15); wr_byte(1, 8'h12);
      w_sel = 3'd0; #0.1; chk("R3", w_rdata, 16'h1510);
      wr_byte(1, 8'h66);
      b_sel = 3'd1; #0.1; chk("R2", {8'h00, b_rdata}, 16'h0060);
      wr_word(0, 16'h1234);
      w_sel = 3'd0; #0.1; chk("R2", w_rdata, 16'h1230);
      wr_word(1, 16'h9775);
      b_sel = 3'd2; #0.1; chk("R3", {8'h00, b_rdata}, 16'h0097);
      b_sel = 3'd3; #0.1; chk("R3", {8'h00, b_rdata}, 16'h0075);

      // R1 / R2 / R3: every value into every byte register
      for (int i = 0; i < 8; i++) begin
         for (int v = 0; v < 256; v++) begin
            wr_byte(i, 8'(v));
            b_sel = 3'(i); #0.1;
            chk((i == 1) ? "R2" : "R1", {8'h00, b_rdata}, {8'h00, eb[i]});
            w_sel = 3'(i / 2); #0.1;
            chk("R3", w_rdata, exp_word(i / 2));
         end
      end
      verify_all("R4");

      // R2 / R3 / R4 / R9: word sweep over every select
      for (int s = 0; s < 8; s++) begin
         for (int k = 0; k < 16; k++) begin
            logic [15:0] v;
            v = (16'(k) * 16'h1111) ^ 16'h2C47 ^ 16'(s * 16'h0301);
            wr_word(s, v);
            w_sel = 3'(s); #0.1;
            chk((s == 0) ? "R2" : (s < 4) ? "R3" : (s < 6) ? "R4" : "R9", w_rdata, exp_word(s));
         end
         verify_all((s < 6) ? "R3" : "R9");
      end

      // R5: overlapping and disjoint simultaneous writes
      b_sel = 3'd3; b_wdata = 8'hAA; b_we = 1'b1;
      w_sel = 3'd1; w_wdata = 16'hBEEF; w_we = 1'b1;
      step(); load_pair(1, 16'hBEEF);
      verify_all("R5");
      b_sel = 3'd0; b_wdata = 8'h5C; b_we = 1'b1;
      w_sel = 3'd1; w_wdata = 16'h1357; w_we = 1'b1;
      step(); eb[0] = 8'h5C; load_pair(1, 16'h1357);
      verify_all("R5");
      b_sel = 3'd1; b_wdata = 8'hFF; b_we = 1'b1;
      w_sel = 3'd0; w_wdata = 16'h2468; w_we = 1'b1;
      step(); load_pair(0, 16'h2468);
      verify_all("R5");

      // R6: flag helpers
      wr_byte(1, 8'h00);
      for (int f = 0; f < 4; f++) begin
         flag_idx = 2'(f); #0.1; chk("R6", {15'h0, flag_rd}, 16'h0000);
         flag_set = 1'b1;
         step(); eb[1] = eb[1] | (8'h80 >> f);
         #0.1; chk("R6", {15'h0, flag_rd}, 16'h0001);
         verify_all("R6");
      end
      for (int f = 0; f < 4; f++) begin
         flag_idx = 2'(f); flag_clr = 1'b1;
         step(); eb[1] = eb[1] & ~(8'h80 >> f);
         #0.1; chk("R6", {15'h0, flag_rd}, 16'h0000);
         verify_all("R6");
      end
      flag_idx = 2'd2; flag_set = 1'b1; flag_clr = 1'b1;
      step(); eb[1] = eb[1] | 8'h20;
      verify_all("R6");
      flag_idx = 2'd0; flag_set = 1'b1;
      b_sel = 3'd1; b_wdata = 8'h40; b_we = 1'b1;
      step(); eb[1] = 8'h40;
      verify_all("R6");
      flag_idx = 2'd1; flag_clr = 1'b1;
      w_sel = 3'd0; w_wdata = 16'h77F0; w_we = 1'b1;
      step(); load_pair(0, 16'h77F0);
      verify_all("R6");

      // R7: reset after writes restores the table
      do_reset(1, 1'b0);
      verify_all("R7");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule